// File: doc/BRIEF.md
# Jitter Attenuator Elastic Buffer Controller

This block is the digital heart of a clock-smoothing loop for a dual-rail line receiver. Each received bit (a positive-rail and a negative-rail flag) goes into a small circular store when the recovered clock strobes. It leaves the store when a local oscillator strobes. The distance between the write and read positions acts as the phase detector. Once per block of read strobes, a 6-bit tuning code moves one step toward the setting that keeps that distance at half the store. An external oscillator follows the code, so the loop is first order.

When the line signal is lost, an alternate reference strobe takes over the write timing if it has been seen recently. If no such reference is present, the tuning code is pinned to mid-scale. Received data reads as zero during the loss. A bypass input sends the incoming rails straight to the outputs. The strobes are single-cycle enables in the `clk` domain. No handshake and no back-pressure exist on either side, because a line cannot be stalled. A position clash is settled by re-centring the pointers and emitting a status pulse.

Top module: `jitter_fifo_ctrl`

## Requirements
- R1: After reset the tuning code is 32, both output rails are 0, both slip pulses are 0 and the reference-present flag is 0.
- R2: With bypass and loss both low, the output rails ({pos,neg}) present stored entries in write order. The first 16 reads return the zero entries left by reset. The rails change on the clock edge that takes a read strobe and hold between reads.
- R3: On every 64th read strobe counted from reset, if the fill (writes minus reads, modulo 32) exceeds 16, the tuning code rises by one, stopping at 63.
- R4: At the same evaluation point, a fill below 16 lowers the code by one, stopping at 0.
- R5: A fill of exactly 16 at the evaluation point leaves the code unchanged.
- R6: A strobe pattern that would bring the fill to 31 instead re-centres it to 16 and raises the overflow pulse for exactly one cycle.
- R7: A strobe pattern that would bring the fill to 0 instead re-centres it to 16 and raises the underflow pulse for exactly one cycle.
- R8: The reference-present flag updates every 256 clock cycles. It becomes 1 when at least one alternate strobe occurred in the window just ended, and 0 otherwise.
- R9: While loss is high and the reference-present flag is 1, alternate strobes write the buffer and recovered strobes are ignored.
- R10: While loss is high and the reference-present flag is 0, the tuning code is forced to 32 from the next cycle on.
- R11: While loss is high and bypass is low, both output rails read 0.
- R12: While bypass is high, the output rails equal the input rails in the same cycle, whatever the loss input.
- R13: While loss is low, alternate strobes write nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Recovered-clock strobe; writes one entry |
| wr_pos | input | 1 | Incoming positive-rail bit |
| wr_neg | input | 1 | Incoming negative-rail bit |
| alt_stb | input | 1 | Alternate reference strobe |
| los | input | 1 | Loss-of-signal indication |
| bypass | input | 1 | Attenuator disabled; rails pass straight through |
| rd_stb | input | 1 | Local-oscillator strobe; reads one entry |
| rd_pos | output | 1 | Outgoing positive-rail bit |
| rd_neg | output | 1 | Outgoing negative-rail bit |
| tune_code | output | 6 | Oscillator tuning code, mid-scale 32 |
| slip_ovf | output | 1 | One-cycle pulse on overflow re-centring |
| slip_unf | output | 1 | One-cycle pulse on underflow re-centring |
| ref_alive | output | 1 | Alternate reference seen in the last window |

## Verification
A random mix of independent write and read strobes, kept inside a safe fill band, checks that the data order matches a bench-side queue primed with 16 zeros. Steady equal-rate strobing at fills of 20, 12 and 16 separates the up, down and hold decisions of the loop, and long runs show saturation at both ends. Write-only and read-only bursts land exactly on the overflow and underflow boundaries, and a second burst of the same length shows that the fill was re-centred. Sparse alternate strobes, strobe-free gaps and loss with and without a reference show which strobe drives the write side, when the code is pinned, and that bypass takes priority.

// File: rtl/jbuf_pkg.sv
package jbuf_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;
endpackage

// File: rtl/jbuf_ptrs.sv
module jbuf_ptrs
  import jbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  rail_t         wr_d,
  input  logic          rd_en,
  output rail_t         rd_d,
  output logic [AW-1:0] fill,
  output logic          slip_ovf,
  output logic          slip_unf
);
  localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);
  localparam logic [AW-1:0] TOP  = AW'(DEPTH - 1);

  rail_t         store [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nx, rptr_adv, fill_nx;
  logic          hit_top, hit_zero;

  always_comb begin
    wptr_nx  = wptr + AW'(wr_en);
    rptr_adv = rptr + AW'(rd_en);
    fill_nx  = wptr_nx - rptr_adv;
    hit_top  = (fill_nx == TOP);
    hit_zero = (fill_nx == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= HALF;
      rptr     <= '0;
      rd_d     <= '0;
      slip_ovf <= 1'b0;
      slip_unf <= 1'b0;
    end else begin
      wptr     <= wptr_nx;
      rptr     <= (hit_top || hit_zero) ? (wptr_nx - HALF) : rptr_adv;
      if (rd_en) rd_d <= store[rptr];
      slip_ovf <= hit_top;
      slip_unf <= hit_zero;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (wr_en) begin
      store[wptr] <= wr_d;
    end
  end

  assign fill = wptr - rptr;

  assert_fill_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != '0) && (fill != TOP));
  assert_ovf_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slip_ovf |=> !slip_ovf);
  assert_unf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    slip_unf |=> !slip_unf);
  assert_slip_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(slip_ovf && slip_unf));
endmodule

// File: rtl/jbuf_loop.sv
module jbuf_loop #(
  parameter int DEPTH      = 32,
  parameter int TUNE_W     = 6,
  parameter int EVAL_READS = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(EVAL_READS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [AW-1:0]     fill,
  input  logic              force_mid,
  output logic [TUNE_W-1:0] code
);
  localparam logic [AW-1:0]     HALF = AW'(DEPTH / 2);
  localparam logic [TUNE_W-1:0] MID  = TUNE_W'(1 << (TUNE_W - 1));
  localparam logic [TUNE_W-1:0] MAXC = '1;
  localparam logic [CW-1:0]     LAST = CW'(EVAL_READS - 1);

  logic [CW-1:0] rd_cnt;
  logic          eval_now;

  assign eval_now = rd_en && (rd_cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      code   <= MID;
    end else begin
      if (rd_en) rd_cnt <= rd_cnt + 1'b1;
      if (force_mid) begin
        code <= MID;
      end else if (eval_now) begin
        if (fill > HALF && code != MAXC) code <= code + 1'b1;
        else if (fill < HALF && code != '0) code <= code - 1'b1;
      end
    end
  end

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !force_mid |=> (code == $past(code) || code == $past(code) + 1'b1 ||
                    code == $past(code) - 1'b1));
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_mid && !rd_en) |=> $stable(code));
  assert_pin_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_mid |=> (code == MID));
endmodule

// File: rtl/jbuf_refdet.sv
module jbuf_refdet #(
  parameter int ALT_WIN = 256,
  localparam int WW = $clog2(ALT_WIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alt_stb,
  output logic alive
);
  localparam logic [WW-1:0] WEND = WW'(ALT_WIN - 1);

  logic [WW-1:0] win;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win   <= '0;
      seen  <= 1'b0;
      alive <= 1'b0;
    end else begin
      win <= win + 1'b1;
      if (win == WEND) begin
        alive <= seen | alt_stb;
        seen  <= 1'b0;
      end else begin
        seen <= seen | alt_stb;
      end
    end
  end

  assert_alive_at_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alive) |-> (win == '0));
endmodule

// File: rtl/jitter_fifo_ctrl.sv
module jitter_fifo_ctrl
  import jbuf_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int TUNE_W     = 6,
  parameter int EVAL_READS = 64,
  parameter int ALT_WIN    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              wr_pos,
  input  logic              wr_neg,
  input  logic              alt_stb,
  input  logic              los,
  input  logic              bypass,
  input  logic              rd_stb,
  output logic              rd_pos,
  output logic              rd_neg,
  output logic [TUNE_W-1:0] tune_code,
  output logic              slip_ovf,
  output logic              slip_unf,
  output logic              ref_alive
);
  localparam int AW = $clog2(DEPTH);

  logic          wr_en;
  rail_t         wr_d, rd_d;
  logic [AW-1:0] fill;
  logic          force_mid;

  always_comb begin
    wr_en     = los ? (ref_alive && alt_stb) : wr_stb;
    wr_d      = los ? '0 : rail_t'{pos: wr_pos, neg: wr_neg};
    force_mid = los && !ref_alive;
  end

  jbuf_refdet #(.ALT_WIN(ALT_WIN)) u_refdet (
    .clk(clk), .rst_n(rst_n), .alt_stb(alt_stb), .alive(ref_alive)
  );

  jbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_d(wr_d), .rd_en(rd_stb),
    .rd_d(rd_d), .fill(fill), .slip_ovf(slip_ovf), .slip_unf(slip_unf)
  );

  jbuf_loop #(.DEPTH(DEPTH), .TUNE_W(TUNE_W), .EVAL_READS(EVAL_READS)) u_loop (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_stb), .fill(fill),
    .force_mid(force_mid), .code(tune_code)
  );

  always_comb begin
    if (bypass) begin
      rd_pos = wr_pos;
      rd_neg = wr_neg;
    end else if (los) begin
      rd_pos = 1'b0;
      rd_neg = 1'b0;
    end else begin
      rd_pos = rd_d.pos;
      rd_neg = rd_d.neg;
    end
  end

  assert_los_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !bypass) |-> (!rd_pos && !rd_neg));
endmodule

// File: tb/jitter_fifo_ctrl_tb_top.sv
module jitter_fifo_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0, wr_pos = 1'b0, wr_neg = 1'b0;
  logic       alt_stb = 1'b0, los = 1'b0, bypass = 1'b0, rd_stb = 1'b0;
  logic       rd_pos, rd_neg, slip_ovf, slip_unf, ref_alive;
  logic [5:0] tune_code;

  int n_tests = 0;
  int n_fail  = 0;
  int ovf_seen = 0;
  int unf_seen = 0;
  logic [1:0] exp_q[$];

  always #2.5 clk = ~clk;

  jitter_fifo_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_pos(wr_pos), .wr_neg(wr_neg),
    .alt_stb(alt_stb), .los(los), .bypass(bypass), .rd_stb(rd_stb),
    .rd_pos(rd_pos), .rd_neg(rd_neg), .tune_code(tune_code),
    .slip_ovf(slip_ovf), .slip_unf(slip_unf), .ref_alive(ref_alive)
  );

  function automatic int sat_step(input int code, input int steps);
    int c = code + steps;
    if (c > 63) c = 63;
    if (c < 0) c = 0;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic a, input logic [1:0] d);
    wr_stb = w; rd_stb = r; alt_stb = a; {wr_pos, wr_neg} = d;
    @(posedge clk);
    @(negedge clk);
    if (slip_ovf) ovf_seen++;
    if (slip_unf) unf_seen++;
    wr_stb = 1'b0; rd_stb = 1'b0; alt_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; los = 1'b0; bypass = 1'b0;
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 2'b00);
    rst_n = 1'b1;
    ovf_seen = 0; unf_seen = 0;
  endtask

  initial begin
    #(50000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] expv, last, d;
    logic w, r;
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 tune", tune_code, 32);
    chk("R1 rails", {rd_pos, rd_neg}, 0);
    chk("R1 slips", {slip_ovf, slip_unf}, 0);
    chk("R1 ref_alive", ref_alive, 0);

    // R2 random traffic against a queue primed with 16 zero entries
    exp_q = {};
    for (int i = 0; i < 16; i++) exp_q.push_back(2'b00);
    last = 2'b00;
    for (int i = 0; i < 3000; i++) begin
      w = 1'($urandom % 2); r = 1'($urandom % 2); d = 2'($urandom % 4);
      if (exp_q.size() >= 28) w = 1'b0;
      if (exp_q.size() <= 3) r = 1'b0;
      if (r) last = exp_q.pop_front();
      if (w) exp_q.push_back(d);
      cyc(w, r, 1'b0, d);
      if (r || (i % 50 == 0)) chk("R2 data order", {rd_pos, rd_neg}, last);
    end
    chk("R6 no slip in band", ovf_seen + unf_seen, 0);

    // R3 fill 20: step up, then saturate
    do_reset();
    repeat (4) cyc(1'b1, 1'b0, 1'b0, 2'b11);
    for (int i = 1; i <= 64 * 33; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 2'b11);
      if (i == 63) chk("R3 before eval", tune_code, 32);
      if (i == 64) chk("R3 first step", tune_code, sat_step(32, 1));
      if (i == 64 * 32) chk("R3 reach top", tune_code, sat_step(32, 32));
    end
    chk("R3 saturate 63", tune_code, sat_step(32, 33));
    chk("R2 data before loss", {rd_pos, rd_neg}, 3);

    // R11 rails low during loss; R10 code pinned without reference
    los = 1'b1;
    #1;
    chk("R11 rails low", {rd_pos, rd_neg}, 0);
    cyc(1'b0, 1'b0, 1'b0, 2'b00);
    chk("R10 code to mid", tune_code, 32);
    los = 1'b0;

    // R4 fill 12: step down, then saturate
    do_reset();
    repeat (4) cyc(1'b0, 1'b1, 1'b0, 2'b00);
    for (int i = 5; i <= 64 * 33; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 2'b10);
      if (i == 64) chk("R4 first step", tune_code, sat_step(32, -1));
    end
    chk("R4 saturate 0", tune_code, sat_step(32, -33));

    // R5 fill 16 holds the code
    do_reset();
    repeat (128) cyc(1'b1, 1'b1, 1'b0, 2'b01);
    chk("R5 hold", tune_code, 32);

    // R6 overflow after 15 writes, twice
    do_reset();
    for (int k = 0; k < 2; k++) begin
      repeat (14) cyc(1'b1, 1'b0, 1'b0, 2'b01);
      chk("R6 no early ovf", slip_ovf, 0);
      cyc(1'b1, 1'b0, 1'b0, 2'b01);
      chk("R6 ovf pulse", slip_ovf, 1);
      cyc(1'b0, 1'b0, 1'b0, 2'b00);
      chk("R6 pulse ends", slip_ovf, 0);
    end
    chk("R6 ovf count", ovf_seen, 2);

    // R7 underflow after 16 reads, twice
    do_reset();
    for (int k = 0; k < 2; k++) begin
      repeat (15) cyc(1'b0, 1'b1, 1'b0, 2'b00);
      chk("R7 no early unf", slip_unf, 0);
      cyc(1'b0, 1'b1, 1'b0, 2'b00);
      chk("R7 unf pulse", slip_unf, 1);
      cyc(1'b0, 1'b0, 1'b0, 2'b00);
      chk("R7 pulse ends", slip_unf, 0);
    end
    chk("R7 unf count", unf_seen, 2);

    // R8 / R13: sparse alternate strobes without loss
    do_reset();
    for (int i = 0; i < 600; i++) cyc(1'b0, 1'b0, (i % 8) == 0, 2'b00);
    chk("R8 ref seen", ref_alive, 1);
    chk("R13 alt ignored", ovf_seen, 0);

    // R9: loss with reference: recovered strobe ignored, alternate writes
    los = 1'b1;
    repeat (20) cyc(1'b1, 1'b0, 1'b0, 2'b11);
    chk("R9 recovered ignored", ovf_seen, 0);
    repeat (14) cyc(1'b0, 1'b0, 1'b1, 2'b00);
    chk("R9 no early ovf", ovf_seen, 0);
    cyc(1'b0, 1'b0, 1'b1, 2'b00);
    chk("R9 alt writes ovf", slip_ovf, 1);
    chk("R10 not pinned with ref", ref_alive, 1);
    los = 1'b0;
    repeat (600) cyc(1'b0, 1'b0, 1'b0, 2'b00);
    chk("R8 ref lost", ref_alive, 0);

    // R12 bypass passes rails, loss or not
    bypass = 1'b1;
    for (int i = 0; i < 8; i++) begin
      los = i[0];
      {wr_pos, wr_neg} = 2'($urandom % 4);
      #1;
      chk("R12 bypass", {rd_pos, rd_neg}, {wr_pos, wr_neg});
      cyc(1'b0, 1'b0, 1'b0, {wr_pos, wr_neg});
    end
    bypass = 1'b0; los = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule